// File: doc/BRIEF.md
# Flash write-buffer load sequencer

This block sits in front of a behavioural flash byte array and accepts the multi-write command that fills a small page buffer and then commits it in one operation. The host issues two unlock writes and a buffer-load command that names a sector. It then writes the byte count minus one, followed by that many address/data loads that all fall in one page, and finally a confirm command at the same sector. Every rule of that sequence is checked. A violation raises a sticky abort flag and throws the buffer away. A correct sequence starts a timed commit, during which the block reports busy and ignores the bus.

The commit is a read-modify-write walk over the page. Only slots that were loaded are written, and each stored byte is the bitwise AND of the new and old contents, so a bit can be cleared but never set. During the commit, the address of the last load is presented as the status address. The array has a second read port so the host can observe its contents.

Top module: `wbuf_seq`

## Requirements
- R1: After reset, `busy`, `abort_flag` and `arr_we` are low and the array reads as all ones.
- R2: The sequence is AAh at 555h, then 55h at 2AAh, then 25h at any address of sector S (address bits [10:8]), then N-1 at sector S, then N loads, then 29h at sector S. This sequence writes every loaded byte into the array.
- R3: A count byte greater than 31 (buffer size 32) aborts the operation.
- R4: The first load must lie in sector S and fixes the page (address bits [10:5]). Any later load outside that page aborts. An aborted buffer never reaches the array.
- R5: Each load decrements the counter, even when it repeats an address. The last data written to an address is the data committed.
- R6: Once the counter is exhausted, any write other than 29h inside sector S aborts. A count write outside sector S also aborts.
- R7: Page slots that were not loaded keep their previous array contents after a commit.
- R8: A committed byte equals the new data ANDed with the old array contents.
- R9: `abort_flag` stays high and all writes are ignored until a write with data F0h or a reset. Either one clears the flag and returns the block to read mode.
- R10: `busy` rises only after an accepted confirm and stays high for exactly `max(PROG_CYC, BUF_BYTES+2)` cycles. Writes during that window are ignored.
- R11: While `busy` is high, `stat_addr` holds the address of the last load.
- R12: A wrong second unlock write, or a wrong command after the unlocks, returns the block to read mode silently. No abort is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | output | 1 | Commit in progress |
| abort_flag | output | 1 | Sticky abort status |
| stat_addr | output | ADDR_W | Address of the last load |
| arr_we | output | 1 | Array write strobe of the commit |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Host read data, one cycle after `rd_addr` |

## Verification
The hardest state to reach from the ports is a commit in which repeated loads, skipped slots and an already-programmed byte all meet in one page. Reaching it takes a full sequence whose counter covers the duplicate. Only then can the last-data-wins rule and the AND merge be seen in the array afterwards. The stimulus programs a page once, leaves gaps in it, and then reprograms one of those bytes with a pattern that would set bits if the merge were missing. Bus writes are injected in the middle of the busy window, and every abort path is followed by a read-back of the page it would have written.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_COUNT, ST_LOAD, ST_CONFIRM, ST_PROG, ST_ABORT
  } wb_state_e;

  localparam int          CMD_ADDR_W   = 11;
  localparam logic [10:0] UNLOCK_ADDR1 = 11'h555;
  localparam logic [10:0] UNLOCK_ADDR2 = 11'h2AA;
  localparam logic [7:0]  UNLOCK_DATA1 = 8'hAA;
  localparam logic [7:0]  UNLOCK_DATA2 = 8'h55;
  localparam logic [7:0]  CMD_LOAD     = 8'h25;
  localparam logic [7:0]  CMD_CONFIRM  = 8'h29;
  localparam logic [7:0]  CMD_CLEAR    = 8'hF0;
endpackage

// File: rtl/wbuf_array.sv
module wbuf_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // erased state: all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/wbuf_page.sv
module wbuf_page #(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  logic                         we,
  input  logic [$clog2(BUF_BYTES)-1:0] widx,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [$clog2(BUF_BYTES)-1:0] ridx,
  output logic [DATA_W-1:0]            rdata,
  output logic                         rvalid
);
  logic [DATA_W-1:0]    slot_q [BUF_BYTES];
  logic [BUF_BYTES-1:0] valid_q;

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == g) slot_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) valid_q <= '0;
    else if (we)      valid_q[widx] <= 1'b1;
  end

  assign rdata  = slot_q[ridx];
  assign rvalid = valid_q[ridx];
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 32,
  parameter int SECT_LSB  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic                         commit_done,
  output logic                         busy,
  output logic                         abort_flag,
  output logic                         load_we,
  output logic [$clog2(BUF_BYTES)-1:0] load_idx,
  output logic [DATA_W-1:0]            load_data,
  output logic                         clear_buf,
  output logic [ADDR_W-$clog2(BUF_BYTES)-1:0] page_hi,
  output logic [ADDR_W-1:0]            stat_addr
);
  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int CNT_W  = IDX_W + 1;
  localparam int SECT_W = ADDR_W - SECT_LSB;
  localparam int PAGE_W = ADDR_W - IDX_W;
  localparam logic [DATA_W-1:0] MAX_CNT = DATA_W'(BUF_BYTES - 1);

  wb_state_e         state_q, nxt;
  logic [SECT_W-1:0] sect_q;
  logic [PAGE_W-1:0] page_q;
  logic              first_q;
  logic [CNT_W-1:0]  left_q;
  logic [ADDR_W-1:0] last_q;
  logic              busy_q, abort_q;

  logic [CMD_ADDR_W-1:0] cmd_addr;
  logic sect_hit, page_hit, load_ok;

  assign cmd_addr = wr_addr[CMD_ADDR_W-1:0];
  assign sect_hit = wr_addr[ADDR_W-1:SECT_LSB] == sect_q;
  assign page_hit = wr_addr[ADDR_W-1:IDX_W] == page_q;
  assign load_ok  = first_q ? sect_hit : page_hit;

  always_comb begin
    nxt     = state_q;
    load_we = 1'b0;
    unique case (state_q)
      ST_READ:
        if (wr_en && cmd_addr == UNLOCK_ADDR1 && wr_data == UNLOCK_DATA1) nxt = ST_UNL1;
      ST_UNL1:
        if (wr_en) nxt = (cmd_addr == UNLOCK_ADDR2 && wr_data == UNLOCK_DATA2) ? ST_UNL2 : ST_READ;
      ST_UNL2:
        if (wr_en) nxt = (wr_data == CMD_LOAD) ? ST_COUNT : ST_READ;
      ST_COUNT:
        if (wr_en) nxt = (!sect_hit || wr_data > MAX_CNT) ? ST_ABORT : ST_LOAD;
      ST_LOAD:
        if (wr_en) begin
          if (!load_ok) nxt = ST_ABORT;
          else begin
            load_we = 1'b1;
            if (left_q == CNT_W'(1)) nxt = ST_CONFIRM;
          end
        end
      ST_CONFIRM:
        if (wr_en) nxt = (sect_hit && wr_data == CMD_CONFIRM) ? ST_PROG : ST_ABORT;
      ST_PROG:
        if (commit_done) nxt = ST_READ;
      ST_ABORT:
        if (wr_en && wr_data == CMD_CLEAR) nxt = ST_READ;
      default: nxt = ST_READ;
    endcase
  end

  assign clear_buf = (nxt == ST_ABORT && state_q != ST_ABORT) ||
                     (state_q == ST_UNL2 && nxt == ST_COUNT);
  assign load_idx  = wr_addr[IDX_W-1:0];
  assign load_data = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_READ;
      sect_q  <= '0;
      page_q  <= '0;
      first_q <= 1'b1;
      left_q  <= '0;
      last_q  <= '0;
      busy_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= nxt;
      busy_q  <= nxt == ST_PROG;
      abort_q <= nxt == ST_ABORT;
      if (state_q == ST_UNL2 && wr_en) sect_q <= wr_addr[ADDR_W-1:SECT_LSB];
      if (state_q == ST_COUNT && nxt == ST_LOAD) begin
        left_q  <= {1'b0, wr_data[IDX_W-1:0]} + CNT_W'(1);
        first_q <= 1'b1;
      end
      if (load_we) begin
        left_q  <= left_q - CNT_W'(1);
        first_q <= 1'b0;
        last_q  <= wr_addr;
        if (first_q) page_q <= wr_addr[ADDR_W-1:IDX_W];
      end
    end
  end

  assign busy       = busy_q;
  assign abort_flag = abort_q;
  assign page_hi    = page_q;
  assign stat_addr  = last_q;

  // R5: the remaining-load counter stays within 1..BUF_BYTES while loading
  assert_left_range_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOAD) |-> (left_q != '0 && left_q <= CNT_W'(BUF_BYTES)));

  // R9: only a clear write releases the abort flag
  assert_abort_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (abort_q && !(wr_en && wr_data == CMD_CLEAR)) |=> abort_q);

  // R10: busy only follows an accepted confirm
  assert_busy_from_confirm_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(state_q) == ST_CONFIRM);

  // R11: status address frozen during the commit
  assert_stat_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> $stable(last_q));
endmodule

// File: rtl/wbuf_commit.sv
module wbuf_commit #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 32,
  parameter int HOLD      = 40
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         active,
  input  logic [ADDR_W-$clog2(BUF_BYTES)-1:0] page_hi,
  input  logic [DATA_W-1:0]            arr_rdata,
  input  logic [DATA_W-1:0]            buf_rdata,
  input  logic                         buf_rvalid,
  output logic [ADDR_W-1:0]            arr_raddr,
  output logic [$clog2(BUF_BYTES)-1:0] buf_ridx,
  output logic                         done,
  output logic                         arr_we,
  output logic [ADDR_W-1:0]            arr_waddr,
  output logic [DATA_W-1:0]            arr_wdata
);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int CW    = $clog2(HOLD + 1);

  logic [CW-1:0]    cnt_q;
  logic             issue, st_v_q;
  logic [IDX_W-1:0] st_idx_q;
  logic             we_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] wdata_q;

  assign issue     = active && cnt_q < CW'(BUF_BYTES);
  assign done      = active && cnt_q == CW'(HOLD - 1);
  assign arr_raddr = {page_hi, cnt_q[IDX_W-1:0]};
  assign buf_ridx  = st_idx_q;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= '0;
    else                cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v_q   <= 1'b0;
      st_idx_q <= '0;
      we_q     <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      st_v_q   <= issue;
      st_idx_q <= cnt_q[IDX_W-1:0];
      we_q     <= st_v_q && buf_rvalid;
      waddr_q  <= {page_hi, st_idx_q};
      wdata_q  <= buf_rdata & arr_rdata;
    end
  end

  assign arr_we    = we_q;
  assign arr_waddr = waddr_q;
  assign arr_wdata = wdata_q;

  // R10: every array write lands inside the busy window
  assert_write_in_window_R10: assert property (@(posedge clk) disable iff (rst)
    we_q |-> active);
endmodule

// File: rtl/wbuf_seq.sv
module wbuf_seq #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 32,
  parameter int SECT_LSB  = 8,
  parameter int PROG_CYC  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              abort_flag,
  output logic [ADDR_W-1:0] stat_addr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W    = $clog2(BUF_BYTES);
  localparam int PAGE_W   = ADDR_W - IDX_W;
  localparam int HOLD_MIN = BUF_BYTES + 2;
  localparam int HOLD     = (PROG_CYC > HOLD_MIN) ? PROG_CYC : HOLD_MIN;

  logic              load_we, clear_buf, done;
  logic [IDX_W-1:0]  load_idx, buf_ridx;
  logic [DATA_W-1:0] load_data, buf_rdata, arr_rdata;
  logic              buf_rvalid;
  logic [PAGE_W-1:0] page_hi;
  logic [ADDR_W-1:0] arr_raddr;

  wbuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .SECT_LSB(SECT_LSB)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_done(done), .busy(busy), .abort_flag(abort_flag),
    .load_we(load_we), .load_idx(load_idx), .load_data(load_data),
    .clear_buf(clear_buf), .page_hi(page_hi), .stat_addr(stat_addr));

  wbuf_page #(.DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES)) u_page (
    .clk(clk), .rst(rst), .clear(clear_buf), .we(load_we), .widx(load_idx),
    .wdata(load_data), .ridx(buf_ridx), .rdata(buf_rdata), .rvalid(buf_rvalid));

  wbuf_commit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .HOLD(HOLD)) u_commit (
    .clk(clk), .rst(rst), .active(busy), .page_hi(page_hi),
    .arr_rdata(arr_rdata), .buf_rdata(buf_rdata), .buf_rvalid(buf_rvalid),
    .arr_raddr(arr_raddr), .buf_ridx(buf_ridx), .done(done),
    .arr_we(arr_we), .arr_waddr(arr_addr), .arr_wdata(arr_wdata));

  wbuf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_addr), .wdata(arr_wdata),
    .raddr_a(arr_raddr), .rdata_a(arr_rdata), .raddr_b(rd_addr), .rdata_b(rd_data));
endmodule

// File: tb/wbuf_seq_bench.sv
module wbuf_seq_bench;
  localparam int HOLD = 40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [10:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy, abort_flag, arr_we;
  logic [10:0] stat_addr, arr_addr, rd_addr;
  logic [7:0]  arr_wdata, rd_data;

  always #4 clk = ~clk;

  wbuf_seq u_wbuf_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .abort_flag(abort_flag), .stat_addr(stat_addr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data));

  typedef struct { int kind; int addr; int exp; string tag; } item_t;
  item_t sbq[$];
  int    n_cmp = 0, n_bad = 0;
  bit    ended = 0;
  byte unsigned model [2048];
  byte unsigned pend [int];
  int    last_load;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind 0: array byte, kind 1: abort flag
  task automatic push(input int kind, input int addr, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.addr = addr; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    rd_addr = '0;
    forever begin
      item_t it;
      int act;
      wait (sbq.size() != 0);
      it = sbq[0];
      @(negedge clk);
      if (it.kind == 0) begin
        rd_addr = it.addr[10:0];
        @(negedge clk);
        act = rd_data;
      end else begin
        act = abort_flag;
      end
      check(it.tag, act, it.exp);
      void'(sbq.pop_front());
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[10:0]; wr_data = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_seq(input int sa, input int cnt);
    pend.delete();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
    wr(sa, 8'h25);
    wr(sa, cnt);
  endtask

  task automatic load(input int a, input int d);
    wr(a, d);
    pend[a] = d[7:0];
    last_load = a;
  endtask

  task automatic confirm(input int sa);
    int n = 0;
    wr(sa, 8'h29);
    while (busy === 1'b1 && n < 1000) begin
      if (n == 2) check("R11 stat_addr during busy", stat_addr, last_load);
      wr_en   = (n == 3 || n == 4);
      wr_addr = 11'h555;
      wr_data = (n == 3) ? 8'hAA : 8'h00;
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check("R10 busy length", n, HOLD);
    foreach (pend[k]) model[k] = model[k] & pend[k];
  endtask

  task automatic clear_abort();
    wr(11'h000, 8'hF0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
    $finish;
  end

  initial begin : driver
    for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy after reset", busy, 0);
    check("R1 abort after reset", abort_flag, 0);
    check("R1 arr_we after reset", arr_we, 0);
    push(0, 11'h000, 8'hFF, "R1 erased array");
    drain();

    // R2 R5 R7: six loads with a repeated address
    start_seq(11'h100, 5);
    load(11'h125, 8'hA5);
    load(11'h120, 8'h3C);
    load(11'h125, 8'h5A);
    load(11'h13F, 8'h0F);
    load(11'h12A, 8'h77);
    load(11'h131, 8'hC3);
    confirm(11'h100);
    push(1, 0, 0, "R2 no abort");
    push(0, 11'h125, model[11'h125], "R5 last data wins");
    push(0, 11'h120, model[11'h120], "R2 byte 120");
    push(0, 11'h13F, model[11'h13F], "R2 byte 13F");
    push(0, 11'h12A, model[11'h12A], "R2 byte 12A");
    push(0, 11'h131, model[11'h131], "R2 byte 131");
    push(0, 11'h121, 8'hFF, "R7 unloaded slot");
    push(0, 11'h11F, 8'hFF, "R7 outside page");
    drain();

    // R8 AND merge on reprogram
    start_seq(11'h1AB, 0);
    load(11'h120, 8'hF0);
    confirm(11'h150);
    push(0, 11'h120, 8'h30, "R8 AND merge");
    push(0, 11'h125, 8'h5A, "R7 neighbour kept");
    drain();

    // R3 count overflow, R9 sticky
    start_seq(11'h100, 32);
    push(1, 0, 1, "R3 count 32 aborts");
    drain();
    wr(11'h555, 8'hAA);
    wr(11'h100, 8'h29);
    push(1, 0, 1, "R9 abort sticky");
    drain();
    clear_abort();
    push(1, 0, 0, "R9 clear write");
    drain();

    // R4 page lock and sector check
    start_seq(11'h300, 3);
    load(11'h340, 8'h11);
    load(11'h360, 8'h22);
    push(1, 0, 1, "R4 out of page aborts");
    drain();
    clear_abort();
    push(0, 11'h340, 8'hFF, "R4 aborted buffer discarded");
    drain();
    start_seq(11'h200, 0);
    load(11'h310, 8'h00);
    push(1, 0, 1, "R4 first load outside sector");
    drain();
    clear_abort();

    // R6 confirm and count checks
    start_seq(11'h400, 0);
    load(11'h480, 8'h00);
    wr(11'h500, 8'h29);
    push(1, 0, 1, "R6 confirm wrong sector");
    drain();
    clear_abort();
    push(0, 11'h480, 8'hFF, "R6 nothing committed");
    drain();
    start_seq(11'h400, 0);
    load(11'h480, 8'h00);
    wr(11'h400, 8'h28);
    push(1, 0, 1, "R6 confirm wrong data");
    drain();
    clear_abort();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
    wr(11'h400, 8'h25);
    wr(11'h500, 8'h00);
    push(1, 0, 1, "R6 count outside sector");
    drain();
    clear_abort();

    // R12 broken unlock returns to read quietly
    wr(11'h555, 8'hAA);
    wr(11'h2AB, 8'h55);
    wr(11'h600, 8'h25);
    wr(11'h600, 8'h00);
    wr(11'h600, 8'h00);
    push(1, 0, 0, "R12 no abort on bad unlock");
    push(0, 11'h600, 8'hFF, "R12 writes ignored in read");
    drain();
    start_seq(11'h600, 1);
    load(11'h600, 8'h12);
    load(11'h601, 8'h34);
    confirm(11'h600);
    push(0, 11'h600, 8'h12, "R12 recovery program");
    push(0, 11'h601, 8'h34, "R12 recovery program");
    drain();

    // R2 full buffer, loaded in reverse order
    start_seq(11'h700, 31);
    for (int i = 31; i >= 0; i--) load(11'h7E0 + i, (i * 7 + 1) & 8'hFF);
    confirm(11'h700);
    for (int i = 0; i < 32; i++) push(0, 11'h7E0 + i, model[11'h7E0 + i], "R2 full buffer");
    drain();

    // R9 reset clears abort
    start_seq(11'h100, 40);
    push(1, 0, 1, "R3 count 40 aborts");
    drain();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 reset clears abort", abort_flag, 0);
    check("R1 busy low after reset", busy, 0);

    ended = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule